// File: doc/BRIEF.md
# Video Pattern Self-Test Controller

This block produces a parallel stream of video test patterns and grades a go/no-go self-test run on that stream. A small configuration port loads a run enable, a 6-bit pattern select code and a colour-bar smoothing enable. While enabled, a raster counter walks pixel, line and field positions, and the pattern logic turns each position into a 20-bit word made of a 10-bit luma half and a 10-bit chroma half. The raster size depends on the selected rate (standard or high definition) and aspect (4:3 or 16:9).

The words leave the block and pass through an external error-check path. That path reports trouble back on a one-cycle error strobe. The controller counts finished fields and raises its pass flag only after two complete fields with no error. Any error keeps the flag low, or pulls it back down, until the run is stopped or restarted.

Raster sizes are parameters, so a reduced raster can show the two-field pass timing within a short run. After reset the block sits at the standard-definition rate. A code with the high-definition bit set moves it to the high rate with no further action.

Top module: `vpat_selftest_top`

## Requirements
- R1: In the cycle after a reset, pix_valid, pix_data, line_start, field_start, field_id, pass_flag, bad_code and hd_rate are all 0. The stored select code is 6'b000000.
- R2: A write (cfg_we=1) always loads cfg_enable and cfg_filter. The select code is loaded only when cfg_sel[3:2]==2'b00, and that write clears bad_code. Any other code keeps the previous pattern and sets bad_code to 1. In the code, bit 5 picks high definition, bit 4 picks 16:9, and bits 1:0 pick the kind: 0 black, 1 equalizer pathological, 2 PLL pathological, 3 colour bars.
- R3: Each write restarts the raster. In the cycle after a write with enable=1, the position is pixel 0, line 0, field 0. The pixel advances every cycle and wraps at the line width: SD_W_STD, SD_W_WIDE, HD_W_STD or HD_W_WIDE, chosen by code bits 5:4. The line wraps after FIELD_LINES lines, and field_id toggles at each wrap. line_start is high at pixel 0. field_start is high at pixel 0 of line 0.
- R4: A word carries luma in bits 19:10 and chroma in bits 9:0. Black gives luma 64 and chroma 512. Equalizer pathological gives luma 0x198 and chroma 0x300. PLL pathological gives luma 0x110 and chroma 0x200.
- R5: Colour bars use bar index floor(8*x/W), where x is the pixel and W is the line width. Bars 0..7 have luma 721,646,525,450,335,260,139,64, Cb 512,176,625,289,735,399,848,512 and Cr 512,567,176,231,793,848,457,512. Chroma carries Cb on even pixels and Cr on odd pixels.
- R6: With the filter enabled, the first pixel of each bar after the first one carries a softened value. That pixel is any x>0 whose bar index differs from that of x-1. Each half of its word is floor((current bar value + previous bar value)/2).
- R7: With no error, pass_flag rises at the end of the second complete field: 2*W*FIELD_LINES cycles after the enabling write's clock edge, and not one cycle earlier.
- R8: An error strobe taken while running, before pass, keeps pass_flag at 0 for the rest of the run.
- R9: An error strobe taken after pass clears pass_flag on the next edge and holds it at 0 until the next write.
- R10: With enable clear, pix_valid, pix_data, line_start, field_start, field_id and pass_flag are 0, and the error strobe has no effect on any later run.
- R11: hd_rate equals bit 5 of the stored select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Run enable written by cfg_we |
| cfg_sel | input | 6 | Pattern select code |
| cfg_filter | input | 1 | Colour-bar smoothing enable |
| err_strobe | input | 1 | Error report from the external check path |
| pix_data | output | 20 | Luma (19:10) and chroma (9:0) word |
| pix_valid | output | 1 | High while the generator runs |
| line_start | output | 1 | First pixel of a line |
| field_start | output | 1 | First pixel of a field |
| field_id | output | 1 | Current field parity |
| hd_rate | output | 1 | High-definition rate selected |
| pass_flag | output | 1 | Self-test passed |
| bad_code | output | 1 | Last written select code was rejected |

## Verification
The assertions check on every cycle that the pixel counter stays below the line width. They also check that the field parity flips at each field end, that pass only rises once two fields are counted, and that pass never coexists with a latched error or a stopped run. The same per-cycle checks cover the rule that a rejected code leaves the stored pattern untouched.

Only the bench's scenarios can show the exact pass cycle and the pixel values of every pattern, including the softened bar edges. The same holds for an error arriving on the very cycle the second field ends, and for the restart behaviour on a rewrite.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

    typedef enum logic [1:0] {
        PAT_BLACK = 2'd0,
        PAT_EQ    = 2'd1,
        PAT_PLL   = 2'd2,
        PAT_BARS  = 2'd3
    } pat_e;

    typedef struct packed {
        logic hd;
        logic wide;
        pat_e kind;
    } cfg_t;

    typedef struct packed {
        logic [9:0] luma;
        logic [9:0] chroma;
    } word_t;

    localparam logic [9:0] BLACK_Y = 10'd64;
    localparam logic [9:0] BLACK_C = 10'd512;
    localparam logic [9:0] EQ_Y    = 10'h198;
    localparam logic [9:0] EQ_C    = 10'h300;
    localparam logic [9:0] PLL_Y   = 10'h110;
    localparam logic [9:0] PLL_C   = 10'h200;

    function automatic logic code_ok(input logic [5:0] code);
        return code[3:2] == 2'b00;
    endfunction

    function automatic cfg_t code_to_cfg(input logic [5:0] code);
        cfg_t c;
        c.hd   = code[5];
        c.wide = code[4];
        c.kind = pat_e'(code[1:0]);
        return c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic [9:0] bar_luma(input logic [2:0] b);
        case (b)
            3'd0:    return 10'd721;
            3'd1:    return 10'd646;
            3'd2:    return 10'd525;
            3'd3:    return 10'd450;
            3'd4:    return 10'd335;
            3'd5:    return 10'd260;
            3'd6:    return 10'd139;
            default: return 10'd64;
        endcase
    endfunction

    function automatic logic [9:0] bar_cb(input logic [2:0] b);
        case (b)
            3'd0:    return 10'd512;
            3'd1:    return 10'd176;
            3'd2:    return 10'd625;
            3'd3:    return 10'd289;
            3'd4:    return 10'd735;
            3'd5:    return 10'd399;
            3'd6:    return 10'd848;
            default: return 10'd512;
        endcase
    endfunction

    function automatic logic [9:0] bar_cr(input logic [2:0] b);
        case (b)
            3'd0:    return 10'd512;
            3'd1:    return 10'd567;
            3'd2:    return 10'd176;
            3'd3:    return 10'd231;
            3'd4:    return 10'd793;
            3'd5:    return 10'd848;
            3'd6:    return 10'd457;
            default: return 10'd512;
        endcase
    endfunction

    function automatic logic [9:0] half_sum(input logic [9:0] a, input logic [9:0] b);
        logic [10:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[10:1];
    endfunction

endpackage

// File: rtl/vpt_cfg_reg.sv
module vpt_cfg_reg
    import vpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       wr_enable,
    input  logic [5:0] wr_sel,
    input  logic       wr_filter,
    output logic       run,
    output cfg_t       cfg,
    output logic       filt,
    output logic       bad
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            cfg  <= code_to_cfg(6'b000000);
            filt <= 1'b0;
            bad  <= 1'b0;
        end else if (wr) begin
            run  <= wr_enable;
            filt <= wr_filter;
            if (code_ok(wr_sel)) begin
                cfg <= code_to_cfg(wr_sel);
                bad <= 1'b0;
            end else begin
                bad <= 1'b1;
            end
        end
    end

    AST_BAD_CODE_KEEPS_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (wr && !code_ok(wr_sel)) |=> ($stable(cfg) && bad)); // R2

    AST_GOOD_CODE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr && code_ok(wr_sel)) |=> (cfg == code_to_cfg($past(wr_sel)) && !bad)); // R2

endmodule

// File: rtl/vpt_raster.sv
module vpt_raster
    import vpt_pkg::*;
#(
    parameter int SD_W_STD    = 720,
    parameter int SD_W_WIDE   = 960,
    parameter int HD_W_STD    = 1440,
    parameter int HD_W_WIDE   = 1920,
    parameter int FIELD_LINES = 262,
    parameter int XW          = 11,
    parameter int YW          = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  cfg_t          cfg,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          fld,
    output logic [XW-1:0] width,
    output logic          field_end
);

    localparam logic [XW-1:0] W_SS = XW'(SD_W_STD);
    localparam logic [XW-1:0] W_SW = XW'(SD_W_WIDE);
    localparam logic [XW-1:0] W_HS = XW'(HD_W_STD);
    localparam logic [XW-1:0] W_HW = XW'(HD_W_WIDE);
    localparam logic [YW-1:0] LAST_Y = YW'(FIELD_LINES - 1);

    logic last_x;
    logic last_y;

    always_comb begin
        case ({cfg.hd, cfg.wide})
            2'b00:   width = W_SS;
            2'b01:   width = W_SW;
            2'b10:   width = W_HS;
            default: width = W_HW;
        endcase
    end

    assign last_x    = (x == width - 1'b1);
    assign last_y    = (y == LAST_Y);
    assign field_end = run && last_x && last_y;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            x   <= '0;
            y   <= '0;
            fld <= 1'b0;
        end else if (last_x) begin
            x <= '0;
            if (last_y) begin
                y   <= '0;
                fld <= ~fld;
            end else begin
                y <= y + 1'b1;
            end
        end else begin
            x <= x + 1'b1;
        end
    end

    AST_PIXEL_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        run |-> (x < width)); // R3

    AST_FIELD_PARITY_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (field_end && !restart) |=> (fld != $past(fld) && x == '0 && y == '0)); // R3

endmodule

// File: rtl/vpt_pattern.sv
module vpt_pattern
    import vpt_pkg::*;
#(
    parameter int XW = 11
) (
    input  cfg_t          cfg,
    input  logic          filt,
    input  logic [XW-1:0] x,
    input  logic [XW-1:0] width,
    output word_t         word
);

    localparam int PW = XW + 3;

    logic [PW-1:0] num_cur;
    logic [PW-1:0] num_prev;
    logic [PW-1:0] den;
    logic [PW-1:0] q_cur;
    logic [PW-1:0] q_prev;
    logic [2:0]    bar_cur;
    logic [2:0]    bar_prev;
    logic          edge_px;
    logic [9:0]    c_cur;
    logic [9:0]    c_prev;

    assign num_cur  = {x, 3'b000};
    assign num_prev = {XW'(x - 1'b1), 3'b000};
    assign den      = PW'(width);
    assign q_cur    = num_cur / den;
    assign q_prev   = num_prev / den;
    assign bar_cur  = q_cur[2:0];
    assign bar_prev = q_prev[2:0];
    assign edge_px  = filt && (x != '0) && (bar_cur != bar_prev);

    assign c_cur  = x[0] ? bar_cr(bar_cur)  : bar_cb(bar_cur);
    assign c_prev = x[0] ? bar_cr(bar_prev) : bar_cb(bar_prev);

    always_comb begin
        case (cfg.kind)
            PAT_BLACK: word = '{luma: BLACK_Y, chroma: BLACK_C};
            PAT_EQ:    word = '{luma: EQ_Y,    chroma: EQ_C};
            PAT_PLL:   word = '{luma: PLL_Y,   chroma: PLL_C};
            default: begin
                if (edge_px) begin
                    word.luma   = half_sum(bar_luma(bar_cur), bar_luma(bar_prev));
                    word.chroma = half_sum(c_cur, c_prev);
                end else begin
                    word.luma   = bar_luma(bar_cur);
                    word.chroma = c_cur;
                end
            end
        endcase
    end

endmodule

// File: rtl/vpt_checker.sv
module vpt_checker (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic field_end,
    input  logic err,
    output logic pass
);

    logic [1:0] fields;
    logic       fail;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            fields <= 2'd0;
            fail   <= 1'b0;
            pass   <= 1'b0;
        end else begin
            if (field_end && fields != 2'd2)
                fields <= fields + 2'd1;
            if (err) begin
                fail <= 1'b1;
                pass <= 1'b0;
            end else if (field_end && fields == 2'd1 && !fail) begin
                pass <= 1'b1;
            end
        end
    end

    AST_PASS_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        pass |-> run); // R10

    AST_ERROR_BLOCKS_PASS: assert property (@(posedge clk) disable iff (rst)
        fail |-> !pass); // R8

    AST_PASS_AFTER_TWO_FIELDS: assert property (@(posedge clk) disable iff (rst)
        $rose(pass) |-> (fields == 2'd2)); // R7

    AST_LATE_ERROR_DROPS_PASS: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && err) |=> !pass); // R9

endmodule

// File: rtl/vpat_selftest_top.sv
module vpat_selftest_top
    import vpt_pkg::*;
#(
    parameter int SD_W_STD    = 720,
    parameter int SD_W_WIDE   = 960,
    parameter int HD_W_STD    = 1440,
    parameter int HD_W_WIDE   = 1920,
    parameter int FIELD_LINES = 262
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_enable,
    input  logic [5:0]  cfg_sel,
    input  logic        cfg_filter,
    input  logic        err_strobe,
    output logic [19:0] pix_data,
    output logic        pix_valid,
    output logic        line_start,
    output logic        field_start,
    output logic        field_id,
    output logic        hd_rate,
    output logic        pass_flag,
    output logic        bad_code
);

    localparam int MAXW = max4(SD_W_STD, SD_W_WIDE, HD_W_STD, HD_W_WIDE);
    localparam int XW   = $clog2(MAXW + 1);
    localparam int YW   = $clog2(FIELD_LINES + 1);

    logic          run;
    cfg_t          cfg;
    logic          filt;
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic          fld;
    logic [XW-1:0] width;
    logic          fend;
    word_t         word;

    vpt_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_we),
        .wr_enable (cfg_enable),
        .wr_sel    (cfg_sel),
        .wr_filter (cfg_filter),
        .run       (run),
        .cfg       (cfg),
        .filt      (filt),
        .bad       (bad_code)
    );

    vpt_raster #(
        .SD_W_STD    (SD_W_STD),
        .SD_W_WIDE   (SD_W_WIDE),
        .HD_W_STD    (HD_W_STD),
        .HD_W_WIDE   (HD_W_WIDE),
        .FIELD_LINES (FIELD_LINES),
        .XW          (XW),
        .YW          (YW)
    ) u_raster (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .restart   (cfg_we),
        .cfg       (cfg),
        .x         (x),
        .y         (y),
        .fld       (fld),
        .width     (width),
        .field_end (fend)
    );

    vpt_pattern #(
        .XW (XW)
    ) u_pattern (
        .cfg   (cfg),
        .filt  (filt),
        .x     (x),
        .width (width),
        .word  (word)
    );

    vpt_checker u_check (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .restart   (cfg_we),
        .field_end (fend),
        .err       (err_strobe),
        .pass      (pass_flag)
    );

    assign pix_valid   = run;
    assign pix_data    = run ? word : 20'd0;
    assign line_start  = run && (x == '0);
    assign field_start = run && (x == '0) && (y == '0);
    assign field_id    = run && fld;
    assign hd_rate     = cfg.hd;

endmodule

// File: tb/tb_vpat_selftest_top.sv
module tb_vpat_selftest_top;

    localparam int CLK_PERIOD = 10;
    localparam int W_SS = 16;
    localparam int W_SW = 24;
    localparam int W_HS = 32;
    localparam int W_HW = 40;
    localparam int NL   = 3;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [5:0]  cfg_sel = 6'd0;
    logic        cfg_filter = 1'b0;
    logic        err_strobe = 1'b0;
    logic [19:0] pix_data;
    logic        pix_valid, line_start, field_start, field_id;
    logic        hd_rate, pass_flag, bad_code;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit compare_on = 1'b0;
    bit finished   = 1'b0;

    // reference model state
    int m_en, m_filt, m_bad, m_hd, m_wide, m_kind;
    int m_x, m_y, m_fld, m_fcnt, m_fail, m_pass;

    int lum_t [8] = '{721, 646, 525, 450, 335, 260, 139, 64};
    int cb_t  [8] = '{512, 176, 625, 289, 735, 399, 848, 512};
    int cr_t  [8] = '{512, 567, 176, 231, 793, 848, 457, 512};

    always #(CLK_PERIOD / 2) clk = ~clk;

    vpat_selftest_top #(
        .SD_W_STD    (W_SS),
        .SD_W_WIDE   (W_SW),
        .HD_W_STD    (W_HS),
        .HD_W_WIDE   (W_HW),
        .FIELD_LINES (NL)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_enable  (cfg_enable),
        .cfg_sel     (cfg_sel),
        .cfg_filter  (cfg_filter),
        .err_strobe  (err_strobe),
        .pix_data    (pix_data),
        .pix_valid   (pix_valid),
        .line_start  (line_start),
        .field_start (field_start),
        .field_id    (field_id),
        .hd_rate     (hd_rate),
        .pass_flag   (pass_flag),
        .bad_code    (bad_code)
    );

    function automatic int m_width();
        if (m_hd != 0) return (m_wide != 0) ? W_HW : W_HS;
        return (m_wide != 0) ? W_SW : W_SS;
    endfunction

    function automatic bit m_edge();
        int w;
        w = m_width();
        return (m_kind == 3) && (m_filt != 0) && (m_x > 0) &&
               ((m_x * 8) / w != ((m_x - 1) * 8) / w);
    endfunction

    function automatic logic [19:0] m_word();
        int w, b, pb, yv, cv;
        if (m_en == 0) return 20'd0;
        case (m_kind)
            0: begin yv = 64;    cv = 512;   end
            1: begin yv = 'h198; cv = 'h300; end
            2: begin yv = 'h110; cv = 'h200; end
            default: begin
                w  = m_width();
                b  = (m_x * 8) / w;
                yv = lum_t[b];
                cv = (m_x % 2 == 0) ? cb_t[b] : cr_t[b];
                if (m_edge()) begin
                    pb = ((m_x - 1) * 8) / w;
                    yv = (yv + lum_t[pb]) / 2;
                    cv = (cv + ((m_x % 2 == 0) ? cb_t[pb] : cr_t[pb])) / 2;
                end
            end
        endcase
        return {yv[9:0], cv[9:0]};
    endfunction

    // model advance on each clock edge, from the inputs only
    always @(posedge clk) begin
        bit fend;
        cycles = cycles + 1;
        if (rst) begin
            m_en = 0; m_filt = 0; m_bad = 0; m_hd = 0; m_wide = 0; m_kind = 0;
            m_x = 0; m_y = 0; m_fld = 0; m_fcnt = 0; m_fail = 0; m_pass = 0;
        end else if (cfg_we) begin
            m_en   = int'(cfg_enable);
            m_filt = int'(cfg_filter);
            if (cfg_sel[3:2] == 2'b00) begin
                m_hd = int'(cfg_sel[5]); m_wide = int'(cfg_sel[4]);
                m_kind = int'(cfg_sel[1:0]); m_bad = 0;
            end else begin
                m_bad = 1;
            end
            m_x = 0; m_y = 0; m_fld = 0; m_fcnt = 0; m_fail = 0; m_pass = 0;
        end else if (m_en != 0) begin
            fend = (m_x == m_width() - 1) && (m_y == NL - 1);
            if (err_strobe) begin
                m_fail = 1; m_pass = 0;
            end else if (fend && m_fcnt == 1 && m_fail == 0) begin
                m_pass = 1;
            end
            if (fend && m_fcnt < 2) m_fcnt = m_fcnt + 1;
            if (m_x == m_width() - 1) begin
                m_x = 0;
                if (m_y == NL - 1) begin m_y = 0; m_fld = 1 - m_fld; end
                else m_y = m_y + 1;
            end else begin
                m_x = m_x + 1;
            end
        end else begin
            m_x = 0; m_y = 0; m_fld = 0; m_fcnt = 0; m_fail = 0; m_pass = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, got, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        string dtag;
        if (compare_on && !finished) begin
            if (m_en == 0) dtag = "R10 data";
            else if (m_kind != 3) dtag = "R4 data";
            else if (m_edge()) dtag = "R6 data";
            else dtag = "R5 data";
            check(dtag, 32'(pix_data), 32'(m_word()));
            check("R10 pix_valid", 32'(pix_valid), 32'(m_en));
            check("R3 line_start", 32'(line_start), 32'(m_en != 0 && m_x == 0));
            check("R3 field_start", 32'(field_start), 32'(m_en != 0 && m_x == 0 && m_y == 0));
            check("R3 field_id", 32'(field_id), 32'(m_en != 0 && m_fld != 0));
            check("R11 hd_rate", 32'(hd_rate), 32'(m_hd));
            check("R7 pass_flag", 32'(pass_flag), 32'(m_pass));
            check("R2 bad_code", 32'(bad_code), 32'(m_bad));
        end
    end

    task automatic write_cfg(input logic en, input logic [5:0] sel, input logic filt);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_enable = en; cfg_sel = sel; cfg_filter = filt;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_err();
        err_strobe = 1'b1;
        @(negedge clk); #1;
        err_strobe = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !finished) begin
            n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int wl;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        // R1: reset state, before any write
        check("R1 pix_valid", 32'(pix_valid), 0);
        check("R1 pix_data", 32'(pix_data), 0);
        check("R1 pass_flag", 32'(pass_flag), 0);
        check("R1 bad_code", 32'(bad_code), 0);
        check("R1 hd_rate", 32'(hd_rate), 0);
        check("R1 field_id", 32'(field_id), 0);
        compare_on = 1'b1;

        // R7: black, SD 4:3, exact pass cycle
        wl = W_SS * NL;
        write_cfg(1'b1, 6'b000000, 1'b0);
        wait_cycles(2 * wl - 1);
        check("R7 pass not early", 32'(pass_flag), 0);
        wait_cycles(1);
        check("R7 pass on time", 32'(pass_flag), 1);
        wait_cycles(wl);
        check("R7 pass held", 32'(pass_flag), 1);

        // R8: equalizer, HD 16:9, error in first field
        wl = W_HW * NL;
        write_cfg(1'b1, 6'b110001, 1'b0);
        check("R11 hd after HD code", 32'(hd_rate), 1);
        wait_cycles(10);
        pulse_err();
        wait_cycles(3 * wl);
        check("R8 no pass after early error", 32'(pass_flag), 0);

        // R8: error on the very cycle the second field ends
        write_cfg(1'b1, 6'b110001, 1'b0);
        wait_cycles(2 * wl - 1);
        pulse_err();
        wait_cycles(wl);
        check("R8 no pass with error at field end", 32'(pass_flag), 0);

        // R5 and R9: bars SD 16:9 unfiltered, error after pass
        wl = W_SW * NL;
        write_cfg(1'b1, 6'b010011, 1'b0);
        wait_cycles(2 * wl + 2);
        check("R9 pass before late error", 32'(pass_flag), 1);
        pulse_err();
        check("R9 pass cleared by late error", 32'(pass_flag), 0);
        wait_cycles(3 * wl);
        check("R9 pass stays low", 32'(pass_flag), 0);

        // R6: bars HD 4:3 filtered, then SD 4:3 filtered
        wl = W_HS * NL;
        write_cfg(1'b1, 6'b100011, 1'b1);
        wait_cycles(2 * wl + 5);
        check("R6 filtered run passes", 32'(pass_flag), 1);
        write_cfg(1'b1, 6'b000011, 1'b1);
        wait_cycles(W_SS * NL);

        // R2: rejected code keeps bars, flags bad code, restarts
        write_cfg(1'b1, 6'b001010, 1'b0);
        check("R2 bad code flagged", 32'(bad_code), 1);
        check("R2 hd kept SD", 32'(hd_rate), 0);
        wait_cycles(W_SS * NL);
        write_cfg(1'b1, 6'b000010, 1'b0);
        check("R2 bad code cleared", 32'(bad_code), 0);
        wait_cycles(2 * W_SS * NL + 2);
        check("R4 PLL run passes", 32'(pass_flag), 1);

        // R10: stop, errors while stopped are ignored
        write_cfg(1'b0, 6'b000010, 1'b0);
        check("R10 stopped valid", 32'(pix_valid), 0);
        check("R10 stopped pass", 32'(pass_flag), 0);
        wait_cycles(5);
        pulse_err();
        wait_cycles(5);
        check("R10 stopped data", 32'(pix_data), 0);
        write_cfg(1'b1, 6'b000000, 1'b0);
        wait_cycles(2 * W_SS * NL + 1);
        check("R10 stopped error had no effect", 32'(pass_flag), 1);

        // R11: HD 16:9 black, then back to SD
        write_cfg(1'b1, 6'b110000, 1'b0);
        check("R11 HD rate", 32'(hd_rate), 1);
        wait_cycles(W_HW * NL + 3);
        write_cfg(1'b1, 6'b000001, 1'b0);
        check("R11 SD rate", 32'(hd_rate), 0);
        wait_cycles(20);

        // R1: reset in mid-run
        @(negedge clk); #1; rst = 1'b1;
        wait_cycles(2);
        rst = 1'b0;
        check("R1 reset mid-run valid", 32'(pix_valid), 0);
        check("R1 reset mid-run pass", 32'(pass_flag), 0);
        wait_cycles(4);
        finish_run();
    end

endmodule